// File: doc/BRIEF.md
# System Reset Control Register

This block is a single-byte register on the I/O bus through which software asks for a full system reset. The register sits at one I/O address, 0xCF9 by default. Writing a byte whose bit 2 is set fires a reset request. Any other write keeps only bit 1, the reset-type selection, and clears every other bit. Reads return the stored byte.

The request leaves the block as a level, `rst_req_o`. It is held for a parameterised minimum number of clocks so that a slow downstream reset sequencer cannot miss it. A trigger write that arrives while the request is already held does not lengthen or restart it. Accesses to any other address are ignored: they get no acknowledge and zero read data.

Every hit access is answered with a one-cycle acknowledge in the clock cycle after it is presented. Read data arrives in that same cycle.

Top module: `sysrst_ctl`

## Requirements
- R1: Only accesses whose `io_addr_i` equals REG_ADDR (default 0xCF9) are decoded. A read or write at REG_ADDR raises `io_ack_o` for exactly one cycle, in the cycle after the access is sampled.
- R2: A write to REG_ADDR with data bit 2 clear stores data bit 1 in bit 1 of the register. All other register bits become zero.
- R3: A write to REG_ADDR with data bit 2 set requests a reset and leaves the stored register value unchanged.
- R4: A read of REG_ADDR returns the stored value on `io_rdata_o` in the acknowledge cycle. If a read and a write are presented together, the write takes effect and read data is zero.
- R5: During and after reset (`rst_ni` low), the stored value is 0x00, and `rst_req_o`, `io_ack_o` and `io_rdata_o` are all low.
- R6: `rst_req_o` rises in the cycle after an accepted trigger write and stays high for exactly STRETCH cycles (default 16). It then falls.
- R7: A trigger write that arrives while `rst_req_o` is high is ignored. The request still falls STRETCH cycles after it first rose.
- R8: Reads and writes at any other address leave the register unchanged, produce no acknowledge and return zero read data.
- R9: `io_rdata_o` is zero in every cycle that does not acknowledge a read of REG_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | ADDR_W | I/O address of the access |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid with `io_ack_o` |
| io_ack_o | output | 1 | Access acknowledge for decoded accesses |
| rst_req_o | output | 1 | Stretched system reset request |

## Verification
The hardest case to reach is a second trigger that lands in the middle of an active request. The bench counts the request's high cycles while it issues a fresh trigger write partway through. It then checks that the total width is still exactly STRETCH cycles. A second hard case is showing that a trigger write leaves the register alone. For this, the bench first stores a non-zero reset-type bit, then writes an all-ones trigger byte, and reads the register back through the normal read port.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned TYPE_BIT = 1;
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;
endpackage

// File: rtl/sysrst_decode.sv
module sysrst_decode
  import sysrst_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              acc_o,
  output logic              rd_hit_o,
  output logic              trig_o,
  output logic              store_we_o,
  output logic [DATA_W-1:0] store_val_o
);
  logic hit, wr_hit;

  always_comb begin
    hit         = (addr_i == REG_ADDR);
    wr_hit      = hit & wr_i;
    acc_o       = hit & (wr_i | rd_i);
    rd_hit_o    = hit & rd_i & ~wr_i;
    trig_o      = wr_hit & wdata_i[TRIG_BIT];
    store_we_o  = wr_hit & ~wdata_i[TRIG_BIT];
    store_val_o = wdata_i & KEEP_MASK;
  end
endmodule

// File: rtl/sysrst_store.sv
module sysrst_store
  import sysrst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              rd_hit_i,
  input  logic              trig_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o
);
  logic [DATA_W-1:0] stored_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= '0;
      rdata_o  <= '0;
      ack_o    <= 1'b0;
    end else begin
      if (we_i) stored_q <= val_i;
      ack_o   <= acc_i;
      rdata_o <= rd_hit_i ? stored_q : '0;
    end
  end

  AST_STORE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_q & ~KEEP_MASK) == '0); // R2
  AST_TRIG_KEEPS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> stored_q == $past(stored_q)); // R3
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == '0); // R9
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
  parameter int unsigned STRETCH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  localparam int unsigned CNT_W = $clog2(STRETCH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  assign busy  = (cnt_q != '0);
  assign req_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i && !busy) cnt_q <= CNT_W'(STRETCH);
    else if (busy)           cnt_q <= cnt_q - 1'b1;
  end

  AST_REQ_FROM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(fire_i)); // R6
  AST_NO_RETRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && fire_i) |=> cnt_q < $past(cnt_q)); // R7
endmodule

// File: rtl/sysrst_ctl.sv
module sysrst_ctl
  import sysrst_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hCF9,
  parameter int unsigned       STRETCH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_ack_o,
  output logic              rst_req_o
);
  logic              acc, rd_hit, trig, store_we;
  logic [DATA_W-1:0] store_val;

  sysrst_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_decode (
    .addr_i      (io_addr_i),
    .wr_i        (io_wr_i),
    .rd_i        (io_rd_i),
    .wdata_i     (io_wdata_i),
    .acc_o       (acc),
    .rd_hit_o    (rd_hit),
    .trig_o      (trig),
    .store_we_o  (store_we),
    .store_val_o (store_val)
  );

  sysrst_store i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .rd_hit_i (rd_hit),
    .trig_i   (trig),
    .we_i     (store_we),
    .val_i    (store_val),
    .rdata_o  (io_rdata_o),
    .ack_o    (io_ack_o)
  );

  sysrst_stretch #(.STRETCH(STRETCH)) i_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (trig),
    .req_o  (rst_req_o)
  );

  AST_ACK_ONLY_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |-> $past(io_addr_i == REG_ADDR && (io_wr_i || io_rd_i))); // R1
  AST_MISS_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i != REG_ADDR) |=> !io_ack_o); // R8
endmodule

// File: tb/test_sysrst_ctl.sv
`timescale 1ns/1ps
module test_sysrst_ctl;
  localparam int unsigned STRETCH = 16;
  localparam logic [15:0] REG = 16'hCF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ack, req;
  int          n_vec = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sysrst_ctl i_sysrst_ctl (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .io_ack_o(ack), .rst_req_o(req)
  );

  task automatic check(string req_id, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_id, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge (one register stage)
  task automatic io_write(logic [15:0] a, logic [7:0] d);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic io_read(logic [15:0] a);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; addr = '0;
  endtask

  task automatic t_reset();
    check("R5 req", req, 0);
    check("R5 ack", ack, 0);
    check("R5 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    io_read(REG);
    check("R5 stored", rdata, 8'h00);
    check("R1 ack read", ack, 1);
    @(negedge clk);
    check("R1 ack one cycle", ack, 0);
    check("R9 idle rdata", rdata, 0);
  endtask

  task automatic t_store();
    io_write(REG, 8'hFB);
    check("R1 ack write", ack, 1);
    check("R2 no req", req, 0);
    io_read(REG);
    check("R2 keep type bit", rdata, 8'h02);
    io_write(REG, 8'h01);
    io_read(REG);
    check("R4 read cleared", rdata, 8'h00);
    io_write(REG, 8'h02);
    addr = REG; rd = 1'b1; wr = 1'b1; wdata = 8'h00;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; addr = '0;
    check("R4 rd+wr rdata", rdata, 0);
    check("R4 rd+wr ack", ack, 1);
    io_read(REG);
    check("R4 rd+wr wrote", rdata, 8'h00);
  endtask

  task automatic t_miss();
    io_write(REG, 8'h02);
    io_write(16'h0CF8, 8'h00);
    check("R8 write miss ack", ack, 0);
    io_write(16'h1CF9, 8'h04);
    check("R8 trig miss req", req, 0);
    io_read(16'h0CFA);
    check("R8 read miss ack", ack, 0);
    check("R8 read miss rdata", rdata, 0);
    io_read(REG);
    check("R8 reg unchanged", rdata, 8'h02);
  endtask

  task automatic t_trigger(bit retrig);
    int w;
    io_write(REG, 8'h02);
    io_write(REG, 8'hFF);
    check("R6 req rises", req, 1);
    w = 0;
    while (req && w < 4 * STRETCH) begin
      w++;
      if (retrig && w == 5) io_write(REG, 8'h04);
      else @(negedge clk);
    end
    if (retrig) check("R7 width unchanged", w, STRETCH);
    else        check("R6 width", w, STRETCH);
    io_read(REG);
    check("R3 reg kept", rdata, 8'h02);
    io_write(REG, 8'h04);
    check("R6 re-arm after release", req, 1);
    repeat (STRETCH + 2) @(negedge clk);
    check("R6 released", req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_store();
    t_miss();
    t_trigger(1'b0);
    t_trigger(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule